// File: doc/BRIEF.md
# Bounded Sparse-Repetition Monitor

This block is a synthesizable checker for a temporal rule on three single-bit signals: a request, a busy indication and a done indication. Once a request has been accepted, busy has to be seen on a bounded number of cycles before done closes the sequence. The busy cycles need not be adjacent. Any number of cycles with busy low may come before, between and after them.

Two parameters, `MIN_CNT` and `MAX_CNT`, set the allowed window for the busy count. One module therefore covers both an exact count (minimum equal to maximum, for example 3 and 3) and a range (for example 2 to 4). The monitor tracks only one pending obligation at a time. It reports each result as a one-cycle pass or fail pulse, and an active flag shows when an obligation is open.

Top module: `nrm_monitor`

## Requirements
- R1: An asynchronous active-low reset clears the active flag, the pass and fail pulses and the busy count. The first sequence after reset release starts from a count of zero.
- R2: When `req_i` is high on a clock edge while the monitor is idle, `active_o` goes high after that edge. Busy and done on the request cycle itself are not evaluated.
- R3: While active, each cycle with `busy_i` high adds one to the count. Cycles with busy low may come in any number between counted cycles without affecting the count.
- R4: While active, `done_i` high on a cycle where the count is at least `MIN_CNT` produces a one-cycle `pass_o` pulse after that edge and returns the monitor to idle. A busy on that same cycle is not counted.
- R5: While active, `done_i` high on a cycle where the count is below `MIN_CNT` does not complete the sequence. Monitoring continues, and a busy on that cycle is still counted.
- R6: While active and without a completing done, `busy_i` high on a cycle where the count already equals `MAX_CNT` produces a one-cycle `fail_o` pulse after that edge and returns the monitor to idle.
- R7: `req_i` high while an obligation is active is ignored. The count and the active flag are unaffected.
- R8: `busy_i` and `done_i` while idle have no effect. No pass or fail follows them.
- R9: `pass_o` and `fail_o` are never high together, and each lasts exactly one cycle.
- R10: The block works both with the default window of exactly 3 and with a window of 2 to 4. The count register is sized from `MAX_CNT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Opens an obligation when idle |
| busy_i | input | 1 | Occurrence to be counted |
| done_i | input | 1 | Terminating event |
| pass_o | output | 1 | One-cycle pulse when the sequence completes within the window |
| fail_o | output | 1 | One-cycle pulse when the count would exceed the window |
| active_o | output | 1 | An obligation is pending |

## Verification
The assertions check on every cycle that the count never rises above `MAX_CNT`, and that pass and fail are exclusive single-cycle pulses. They also check that a completing done or an overflowing busy is followed by the matching pulse, that an idle cycle never yields a result, and that an idle request always opens an obligation. Only the bench's scenarios can show the whole temporal rule at work. These cover the counting of sparse busy cycles across padding, a premature done being ignored in the exact window but accepted in the wider one, the priority of done over busy on a shared cycle, requests dropped while active, and a reset in mid-sequence discarding the partial count. Each scenario runs against both window configurations.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_TRACK = 1'b1
  } nrm_state_e;

endpackage

// File: rtl/nrm_counter.sv
module nrm_counter #(
  parameter int MIN_CNT = 3,
  parameter int MAX_CNT = 3,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o,
  output logic             min_ok_o
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CNT);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_max_o = (cnt_q == MAX_V);

  generate
    if (MIN_CNT == 0) begin : g_min_zero
      assign min_ok_o = 1'b1;
    end else begin : g_min_cmp
      assign min_ok_o = (cnt_q >= MIN_V);
    end
  endgenerate

  assign cnt_o = cnt_q;

endmodule

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic at_max_i,
  input  logic min_ok_i,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic active_o,
  output logic pass_o,
  output logic fail_o
);

  nrm_state_e state_q, state_d;
  logic       pass_q, pass_d;
  logic       fail_q, fail_d;

  always_comb begin
    state_d   = state_q;
    pass_d    = 1'b0;
    fail_d    = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d   = ST_TRACK;
          cnt_clr_o = 1'b1;
        end
      end
      ST_TRACK: begin
        if (done_i && min_ok_i) begin
          pass_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (busy_i) begin
          if (at_max_i) begin
            fail_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  assign active_o = (state_q == ST_TRACK);
  assign pass_o   = pass_q;
  assign fail_o   = fail_q;

endmodule

// File: rtl/nrm_monitor.sv
module nrm_monitor #(
  parameter int MIN_CNT = 3,
  parameter int MAX_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  input  logic done_i,
  output logic pass_o,
  output logic fail_o,
  output logic active_o
);

  localparam int CNT_W = $clog2(MAX_CNT + 2);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             at_max;
  logic             min_ok;

  nrm_counter #(
    .MIN_CNT (MIN_CNT),
    .MAX_CNT (MAX_CNT),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cnt_clr),
    .inc_i    (cnt_inc),
    .cnt_o    (cnt),
    .at_max_o (at_max),
    .min_ok_o (min_ok)
  );

  nrm_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .busy_i    (busy_i),
    .done_i    (done_i),
    .at_max_i  (at_max),
    .min_ok_i  (min_ok),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .active_o  (active_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
  );

endmodule

// File: rtl/nrm_monitor_chk.sv
module nrm_monitor_chk #(
  parameter int MIN_CNT = 3,
  parameter int MAX_CNT = 3,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             pass_o,
  input logic             fail_o,
  input logic             active_o,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CNT);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAX_V); // R6

  AST_START_OBLIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && req_i) |=> active_o); // R2

  AST_PASS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && done_i && (cnt >= MIN_V)) |=> (pass_o && !active_o)); // R4

  AST_FAIL_ON_EXCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && busy_i && (cnt == MAX_V) && !(done_i && (cnt >= MIN_V)))
      |=> (fail_o && !active_o)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> (!pass_o && !fail_o)); // R8

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o)); // R9

  AST_PASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |=> !pass_o); // R9

  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o); // R9

endmodule

bind nrm_monitor nrm_monitor_chk #(
  .MIN_CNT (MIN_CNT),
  .MAX_CNT (MAX_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .busy_i   (busy_i),
  .done_i   (done_i),
  .pass_o   (pass_o),
  .fail_o   (fail_o),
  .active_o (active_o),
  .cnt      (cnt)
);

// File: tb/nrm_monitor_tb.sv
module nrm_monitor_tb;

  logic clk;
  logic rst_n;
  logic req, busy, done;
  logic pass_a, fail_a, act_a;
  logic pass_b, fail_b, act_b;

  int checks;
  int failures;
  bit finished;

  // Row layout: {req, busy, done, pass_a, fail_a, active_a, pass_b, fail_b, active_b}
  // Expected values are the outputs after the edge that closes the row's cycle.
  // Config a: window exactly 3; config b: window 2 to 4 (R10).
  localparam int NV = 39;
  localparam logic [8:0] VEC [NV] = '{
    9'b000_000_000, // 0  idle
    9'b100_001_001, // 1  request opens obligation (R2)
    9'b010_001_001, // 2  busy #1 (R3)
    9'b000_001_001, // 3  padding
    9'b010_001_001, // 4  busy #2
    9'b000_001_001, // 5
    9'b010_001_001, // 6  busy #3
    9'b000_001_001, // 7
    9'b001_100_100, // 8  done -> pass both (R4)
    9'b000_000_000, // 9
    9'b100_001_001, // 10 request
    9'b010_001_001, // 11
    9'b010_001_001, // 12
    9'b010_001_001, // 13
    9'b010_010_001, // 14 fourth busy: a fails (R6)
    9'b010_000_010, // 15 fifth busy: b fails, a idle ignores
    9'b000_000_000, // 16
    9'b100_001_001, // 17 request
    9'b010_001_001, // 18
    9'b010_001_001, // 19
    9'b001_001_100, // 20 early done: a continues (R5), b passes
    9'b010_001_000, // 21 busy counts in a
    9'b001_100_000, // 22 a passes
    9'b000_000_000, // 23
    9'b100_001_001, // 24 request
    9'b110_001_001, // 25 request while active ignored (R7)
    9'b010_001_001, // 26
    9'b100_001_001, // 27 request while active ignored
    9'b011_001_100, // 28 busy+done: a counts, b passes (done wins)
    9'b001_100_000, // 29 a passes, b idle
    9'b101_001_001, // 30 done on request cycle not evaluated
    9'b001_001_001, // 31 done with count 0
    9'b010_001_001, // 32
    9'b010_001_001, // 33
    9'b001_001_100, // 34
    9'b010_001_000, // 35
    9'b001_100_000, // 36
    9'b010_000_000, // 37 busy while idle ignored (R8)
    9'b001_000_000  // 38 done while idle ignored
  };

  nrm_monitor #(.MIN_CNT(3), .MAX_CNT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .done_i(done),
    .pass_o(pass_a), .fail_o(fail_a), .active_o(act_a)
  );

  nrm_monitor #(.MIN_CNT(2), .MAX_CNT(4)) u_dut_win (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .done_i(done),
    .pass_o(pass_b), .fail_o(fail_b), .active_o(act_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    if (i < 10) return "R3/R4";
    if (i < 17) return "R6";
    if (i < 24) return "R5";
    if (i < 30) return "R7";
    return "R8";
  endfunction

  task automatic drive(input logic r, input logic b, input logic d);
    @(negedge clk);
    req = r; busy = b; done = d;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    req = 1'b0; busy = 1'b0; done = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "active_a", act_a, 1'b0);
    chk("R1", "pass_a",   pass_a, 1'b0);
    chk("R1", "fail_a",   fail_a, 1'b0);
    chk("R1", "active_b", act_b, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6]);
      @(posedge clk);
      #2;
      chk(row_tag(i), $sformatf("row%0d pass_a", i), pass_a, VEC[i][5]);
      chk(row_tag(i), $sformatf("row%0d fail_a", i), fail_a, VEC[i][4]);
      chk(row_tag(i), $sformatf("row%0d act_a",  i), act_a,  VEC[i][3]);
      chk(row_tag(i), $sformatf("row%0d pass_b", i), pass_b, VEC[i][2]);
      chk(row_tag(i), $sformatf("row%0d fail_b", i), fail_b, VEC[i][1]);
      chk(row_tag(i), $sformatf("row%0d act_b",  i), act_b,  VEC[i][0]);
    end

    // R1: reset in mid-sequence drops the obligation and the partial count
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    req = 1'b0; busy = 1'b0; done = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "async active_a", act_a, 1'b0);
    chk("R1", "async active_b", act_b, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b1);
    @(posedge clk);
    #2;
    chk("R1", "done after reset pass_a", pass_a, 1'b0);
    chk("R1", "done after reset pass_b", pass_b, 1'b0);

    // R10: consecutive busy run of exactly three passes both windows
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    @(posedge clk);
    #2;
    chk("R10", "back-to-back pass_a", pass_a, 1'b1);
    chk("R10", "back-to-back pass_b", pass_b, 1'b1);
    chk("R9", "fail_a with pass", fail_a, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #2;
    chk("R9", "pass_a single cycle", pass_a, 1'b0);
    chk("R9", "pass_b single cycle", pass_b, 1'b0);

    finish_run();
  end

endmodule